// File: doc/BRIEF.md
# PLL Holdover Controller with Digital Lock Detect

This block decides when a phase-locked loop stops steering its oscillator and coasts (holdover), and when it resumes. It counts consecutive phase-detector comparisons whose edges fall inside the lock window and declares digital lock once a selectable count is reached. The count is kept per comparison, and any comparison outside the window clears it.

In holdover the block tri-states the charge pump. It holds that state until a comparison event arrives from the currently selected reference. On that event it releases the charge pump and, in the same cycle, pulses a synchronous reset to the feedback divider's B counter so that the divider edges line up again. The prescaler is left running. After an exit, the controller will not enter holdover again until the loop has regained digital lock. When the lock-pin comparator is enabled, it also waits for the sampled lock-pin level to read high.

Entry follows loss of digital lock in automatic mode, or a request input in external mode. A master enable can switch off both modes. The charge pump, the phase detector, the dividers and the lock-pin capacitor are outside this block.

Top module: `pll_holdover_ctrl`

## Requirements
- R1: After reset, cp_hiz_o, b_rst_o, dld_o and armed_o are all 0 and the lock count is zero.
- R2: dld_o goes high in the cycle after the Nth consecutive event with pfd_evt_i=1 and in_win_i=1. N is 5, 16, 64 or 255 for lock_sel_i codes 0, 1, 2 and 3. After N-1 such events dld_o is still 0.
- R3: An event with pfd_evt_i=1 and in_win_i=0 clears the count, and dld_o is 0 in the next cycle.
- R4: In automatic mode (ext_mode_i=0), when armed_o=1 and lock is lost, cp_hiz_o is 1 two cycles after the out-of-window event.
- R5: While in holdover with ho_en_i=1, cp_hiz_o stays 1 on every cycle without a pfd_evt_i/ref_ok_i pair.
- R6: In holdover, a cycle with pfd_evt_i=1 and ref_ok_i=1 drives b_rst_o=1 in that same cycle, and cp_hiz_o is 0 in the next cycle.
- R7: After an exit, armed_o rises only after digital lock and a high pin level are both seen. A pin level of 0 blocks re-arming when pin_cmp_en_i=1 and has no effect when pin_cmp_en_i=0. While not armed, no entry happens.
- R8: With dld_dis_i=1, dld_o is 0 and automatic mode never enters holdover.
- R9: With ho_en_i=0, cp_hiz_o and b_rst_o are 0 in that same cycle and the block returns to the unarmed state.
- R10: In external mode (ext_mode_i=1), holdover is entered when ext_req_i=1 while armed, whatever the lock state. It is left only on a reference event while ext_req_i=0.
- R11: A loss of lock, such as during a reference switchover, keeps the charge pump tri-stated only until the first reference event at the phase detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pfd_evt_i | input | 1 | Phase-detector comparison event on the selected reference path |
| in_win_i | input | 1 | Edges of the current event inside the lock window |
| ref_ok_i | input | 1 | Selected reference clock present |
| ld_pin_i | input | 1 | Sampled lock-pin level |
| ho_en_i | input | 1 | Holdover master enable |
| ext_mode_i | input | 1 | 1 = external request mode, 0 = automatic mode |
| ext_req_i | input | 1 | External holdover request |
| pin_cmp_en_i | input | 1 | Lock-pin comparator enable |
| dld_dis_i | input | 1 | Disable digital lock detect |
| lock_sel_i | input | 2 | Lock count select |
| cp_hiz_o | output | 1 | Charge pump tri-state (holdover active) |
| b_rst_o | output | 1 | Synchronous reset pulse for the feedback B counter |
| dld_o | output | 1 | Digital lock status |
| armed_o | output | 1 | Holdover entry currently allowed |

## Verification
The bench builds the block with its default lock counts of 5, 16, 64 and 255. It sweeps every select code to exactly N-1 and N in-window events, and each sweep ends with an out-of-window event. Because the largest count is only a few hundred cycles, each threshold boundary is checked directly rather than at scaled-down values. The bench then walks the state sequence wait, armed, holdover, exit and wait. It does this in automatic mode with the pin comparator on and off, with lock detect disabled, with the master enable dropped during holdover, and in external mode.

// File: rtl/pll_ho_pkg.sv
package pll_ho_pkg;
  typedef enum logic [1:0] {
    HO_WAIT = 2'd0,
    HO_RUN  = 2'd1,
    HO_HOLD = 2'd2
  } ho_state_e;
endpackage

// File: rtl/pll_ho_lock_det.sv
module pll_ho_lock_det #(
  parameter int unsigned N0    = 5,
  parameter int unsigned N1    = 16,
  parameter int unsigned N2    = 64,
  parameter int unsigned N3    = 255,
  parameter int unsigned CNT_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pfd_evt_i,
  input  logic       in_win_i,
  input  logic [1:0] lock_sel_i,
  output logic       lock_o
);
  localparam int unsigned NSEL = 4;
  logic [CNT_W-1:0] tgt_tab [NSEL];
  logic [CNT_W-1:0] tgt;
  logic [CNT_W-1:0] cnt_q;

  assign tgt_tab[0] = CNT_W'(N0);
  assign tgt_tab[1] = CNT_W'(N1);
  assign tgt_tab[2] = CNT_W'(N2);
  assign tgt_tab[3] = CNT_W'(N3);
  assign tgt        = tgt_tab[lock_sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (pfd_evt_i) begin
      if (!in_win_i)             cnt_q <= '0;
      else if (cnt_q < tgt)      cnt_q <= cnt_q + 1'b1;  // saturate at target
    end
  end

  assign lock_o = (cnt_q >= tgt) && (cnt_q != '0);
endmodule

// File: rtl/pll_ho_fsm.sv
module pll_ho_fsm
  import pll_ho_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pfd_evt_i,
  input  logic ref_ok_i,
  input  logic lock_i,
  input  logic pin_ok_i,
  input  logic ho_en_i,
  input  logic ext_mode_i,
  input  logic ext_req_i,
  input  logic dld_dis_i,
  output logic cp_hiz_o,
  output logic b_rst_o,
  output logic armed_o
);
  ho_state_e st_q, st_d;
  logic enter, leave;

  assign enter = ext_mode_i ? ext_req_i : (!dld_dis_i && !lock_i);
  assign leave = pfd_evt_i && ref_ok_i && !(ext_mode_i && ext_req_i);

  always_comb begin
    st_d = st_q;
    if (!ho_en_i) st_d = HO_WAIT;
    else begin
      unique case (st_q)
        HO_WAIT: if (lock_i && pin_ok_i) st_d = HO_RUN;
        HO_RUN:  if (enter)              st_d = HO_HOLD;
        HO_HOLD: if (leave)              st_d = HO_WAIT;
        default:                         st_d = HO_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= HO_WAIT;
    else         st_q <= st_d;
  end

  assign cp_hiz_o = (st_q == HO_HOLD) && ho_en_i;
  assign b_rst_o  = cp_hiz_o && leave;
  assign armed_o  = (st_q == HO_RUN);
endmodule

// File: rtl/pll_holdover_ctrl.sv
module pll_holdover_ctrl #(
  parameter int unsigned LOCK_N0 = 5,
  parameter int unsigned LOCK_N1 = 16,
  parameter int unsigned LOCK_N2 = 64,
  parameter int unsigned LOCK_N3 = 255
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pfd_evt_i,
  input  logic       in_win_i,
  input  logic       ref_ok_i,
  input  logic       ld_pin_i,
  input  logic       ho_en_i,
  input  logic       ext_mode_i,
  input  logic       ext_req_i,
  input  logic       pin_cmp_en_i,
  input  logic       dld_dis_i,
  input  logic [1:0] lock_sel_i,
  output logic       cp_hiz_o,
  output logic       b_rst_o,
  output logic       dld_o,
  output logic       armed_o
);
  localparam int unsigned NMAX  = (LOCK_N0 > LOCK_N1 ? LOCK_N0 : LOCK_N1) >
                                  (LOCK_N2 > LOCK_N3 ? LOCK_N2 : LOCK_N3) ?
                                  (LOCK_N0 > LOCK_N1 ? LOCK_N0 : LOCK_N1) :
                                  (LOCK_N2 > LOCK_N3 ? LOCK_N2 : LOCK_N3);
  localparam int unsigned CNT_W = $clog2(NMAX + 1);

  logic lock_raw, pin_ok;

  pll_ho_lock_det #(
    .N0(LOCK_N0), .N1(LOCK_N1), .N2(LOCK_N2), .N3(LOCK_N3), .CNT_W(CNT_W)
  ) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pfd_evt_i  (pfd_evt_i),
    .in_win_i   (in_win_i),
    .lock_sel_i (lock_sel_i),
    .lock_o     (lock_raw)
  );

  // disabled comparator reads as a charged pin
  assign pin_ok = !pin_cmp_en_i || ld_pin_i;

  pll_ho_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pfd_evt_i  (pfd_evt_i),
    .ref_ok_i   (ref_ok_i),
    .lock_i     (lock_raw),
    .pin_ok_i   (pin_ok),
    .ho_en_i    (ho_en_i),
    .ext_mode_i (ext_mode_i),
    .ext_req_i  (ext_req_i),
    .dld_dis_i  (dld_dis_i),
    .cp_hiz_o   (cp_hiz_o),
    .b_rst_o    (b_rst_o),
    .armed_o    (armed_o)
  );

  assign dld_o = lock_raw && !dld_dis_i;
endmodule

// File: rtl/pll_holdover_ctrl_chk.sv
module pll_holdover_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pfd_evt_i,
  input logic in_win_i,
  input logic ref_ok_i,
  input logic ho_en_i,
  input logic ext_mode_i,
  input logic dld_dis_i,
  input logic cp_hiz_o,
  input logic b_rst_o,
  input logic dld_o
);
  AST_BRST_ON_REF_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_rst_o |-> (pfd_evt_i && ref_ok_i)); // R6
  AST_EXIT_RELEASES_CP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_rst_o |=> !cp_hiz_o); // R6
  AST_HIZ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_hiz_o && ho_en_i && !(pfd_evt_i && ref_ok_i)) |=> (cp_hiz_o || !ho_en_i)); // R5
  AST_MISS_DROPS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pfd_evt_i && !in_win_i) |=> !dld_o); // R3
  AST_AUTO_NEEDS_DLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cp_hiz_o) && $past(!ext_mode_i)) |-> $past(!dld_dis_i)); // R8
endmodule

bind pll_holdover_ctrl pll_holdover_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pfd_evt_i  (pfd_evt_i),
  .in_win_i   (in_win_i),
  .ref_ok_i   (ref_ok_i),
  .ho_en_i    (ho_en_i),
  .ext_mode_i (ext_mode_i),
  .dld_dis_i  (dld_dis_i),
  .cp_hiz_o   (cp_hiz_o),
  .b_rst_o    (b_rst_o),
  .dld_o      (dld_o)
);

// File: tb/pll_holdover_ctrl_tb.sv
`timescale 1ns/1ps
module pll_holdover_ctrl_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pfd_evt_i = 0, in_win_i = 0, ref_ok_i = 1, ld_pin_i = 0;
  logic ho_en_i = 0, ext_mode_i = 0, ext_req_i = 0, pin_cmp_en_i = 1, dld_dis_i = 0;
  logic [1:0] lock_sel_i = 2'd0;
  logic cp_hiz_o, b_rst_o, dld_o, armed_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  pll_holdover_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pfd_evt_i(pfd_evt_i), .in_win_i(in_win_i),
    .ref_ok_i(ref_ok_i), .ld_pin_i(ld_pin_i), .ho_en_i(ho_en_i),
    .ext_mode_i(ext_mode_i), .ext_req_i(ext_req_i), .pin_cmp_en_i(pin_cmp_en_i),
    .dld_dis_i(dld_dis_i), .lock_sel_i(lock_sel_i), .cp_hiz_o(cp_hiz_o),
    .b_rst_o(b_rst_o), .dld_o(dld_o), .armed_o(armed_o)
  );

  function automatic int lock_n(int sel);
    case (sel)
      0: return 5;
      1: return 16;
      2: return 64;
      default: return 255;
    endcase
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk_i);
    #1;
  endtask

  task automatic ev(logic win, int n);
    for (int i = 0; i < n; i++) begin
      pfd_evt_i = 1; in_win_i = win;
      tick;
      pfd_evt_i = 0; in_win_i = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    tick;
    chk("R1 cp_hiz", cp_hiz_o, 0);
    chk("R1 b_rst", b_rst_o, 0);
    chk("R1 dld", dld_o, 0);
    chk("R1 armed", armed_o, 0);

    // R2/R3 threshold sweep, holdover disabled
    for (int s = 0; s < 4; s++) begin
      lock_sel_i = 2'(s);
      ev(1, lock_n(s) - 1);
      chk("R2 below count", dld_o, 0);
      ev(1, 1);
      chk("R2 at count", dld_o, 1);
      ev(1, 3);
      chk("R2 saturated", dld_o, 1);
      ev(0, 1);
      chk("R3 miss clears", dld_o, 0);
      ev(1, lock_n(s) - 1);
      chk("R3 count restarted", dld_o, 0);
      ev(0, 1);
    end
    lock_sel_i = 0;

    // automatic mode, comparator on
    ho_en_i = 1; pin_cmp_en_i = 1; ld_pin_i = 0; ref_ok_i = 1;
    ev(1, 5);
    tick;
    chk("R7 pin low blocks arm", armed_o, 0);
    ld_pin_i = 1;
    tick;
    chk("R7 arm with lock+pin", armed_o, 1);
    ev(0, 1);
    chk("R3 dld low", dld_o, 0);
    chk("R4 not yet", cp_hiz_o, 0);
    tick;
    chk("R4 entry", cp_hiz_o, 1);
    ref_ok_i = 0;
    tick; tick; tick;
    chk("R5 held without ref", cp_hiz_o, 1);
    ref_ok_i = 1; pfd_evt_i = 1; in_win_i = 1;
    #0.1;
    chk("R6 b_rst same cycle", b_rst_o, 1);
    chk("R11 first ref edge ends", cp_hiz_o, 1);
    tick;
    pfd_evt_i = 0; in_win_i = 0;
    #0.1;
    chk("R6 cp released", cp_hiz_o, 0);
    chk("R6 pulse ended", b_rst_o, 0);
    chk("R7 unarmed after exit", armed_o, 0);

    // re-entry blocked until relock
    ev(0, 1);
    tick; tick;
    chk("R7 no re-entry", cp_hiz_o, 0);
    ld_pin_i = 0;
    ev(1, 5);
    tick;
    chk("R7 pin low still blocks", armed_o, 0);
    pin_cmp_en_i = 0;
    tick;
    chk("R7 comparator off", armed_o, 1);
    ev(0, 1); tick;
    chk("R11 lock loss enters", cp_hiz_o, 1);
    pfd_evt_i = 1; in_win_i = 0;
    #0.1;
    chk("R11 exit at next edge", b_rst_o, 1);
    tick;
    pfd_evt_i = 0;
    chk("R11 released", cp_hiz_o, 0);

    // R8 lock detect disabled
    dld_dis_i = 1;
    ev(1, 5);
    chk("R8 dld forced low", dld_o, 0);
    tick;
    chk("R8 arms on raw lock", armed_o, 1);
    ev(0, 1); tick; tick;
    chk("R8 no auto entry", cp_hiz_o, 0);
    dld_dis_i = 0;
    tick;
    chk("R8 entry once enabled", cp_hiz_o, 1);

    // R9 master enable
    ho_en_i = 0;
    #0.1;
    chk("R9 cp released at once", cp_hiz_o, 0);
    pfd_evt_i = 1; ref_ok_i = 1;
    #0.1;
    chk("R9 no b_rst", b_rst_o, 0);
    pfd_evt_i = 0;
    tick;
    ho_en_i = 1;
    tick;
    chk("R9 back to unarmed", armed_o, 0);
    chk("R9 no holdover", cp_hiz_o, 0);

    // R10 external mode
    ext_mode_i = 1; pin_cmp_en_i = 0;
    ev(1, 5); tick;
    chk("R10 armed", armed_o, 1);
    ev(0, 1); tick; tick;
    chk("R10 lock loss ignored", cp_hiz_o, 0);
    ext_req_i = 1;
    tick;
    chk("R10 request enters", cp_hiz_o, 1);
    pfd_evt_i = 1;
    #0.1;
    chk("R10 held while requested", b_rst_o, 0);
    tick;
    chk("R10 still holding", cp_hiz_o, 1);
    ext_req_i = 0;
    #0.1;
    chk("R10 exit on ref edge", b_rst_o, 1);
    tick;
    pfd_evt_i = 0;
    chk("R10 released", cp_hiz_o, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule